// File: doc/BRIEF.md
# Root-Port Link Bring-up Sequencer

This block walks a root-port link from reset to a trained, speed-negotiated state. After a start pulse it caps the advertised maximum link speed at Gen1 and only then enables link training, so that devices sitting behind switches are found reliably. Once the link reports up, it raises the cap to Gen2 and issues a directed speed change. It then polls the speed-change bit until the core clears it, and waits for the link to be up with training settled before it reports success together with the negotiated generation.

Every wait is bounded. The link-up waits use a cycle budget supplied at a port, and the speed-change poll is limited to a fixed number of reads. When any step runs out of time, the sequencer holds the receiver data-enable and receiver PLL-enable overrides of the PHY for a fixed recovery window, releases them, and reports failure. The core-side fields are driven as plain levels or pulses, and the status words are sampled as plain 32-bit inputs.

Top module: `link_bringup_seq`

## Requirements
- R1: After reset, done_o, fail_o, gen_o, ltssm_en_o, speed_req_o, max_speed_o and rx_ovrd_o are all zero.
- R2: A start that is accepted writes max_speed_o = 1 (Gen1) one cycle before ltssm_en_o rises. max_speed_o equals 1 in the first cycle in which ltssm_en_o is high.
- R3: While the sequencer waits for the first link-up, status_i bit 4 = 1 makes max_speed_o = 2 (Gen2). One cycle later, speed_req_o pulses high for exactly one cycle, and max_speed_o is already 2 during that pulse.
- R4: From the cycle after the pulse, spd_ctl_i bit 17 is sampled once per cycle, up to POLL_MAX (200) times. A 0 ends the poll, even on the last allowed read. If 200 consecutive reads all return 1, recovery starts in the 201st cycle after the pulse.
- R5: After the poll, the first cycle with status_i bit 4 = 1 and bit 29 = 0 moves the sequencer to done. gen_o then holds the value that lcs_i bits 19:16 had in that cycle.
- R6: Each link-up wait gives up after link_tmo_i + 1 samples that fail its condition. For the first wait, recovery starts link_tmo_i + 1 cycles after ltssm_en_o rises.
- R7: Recovery drives rx_ovrd_o = 16'h0028 (bit 5 and bit 3 set) for exactly RECOV_CYCLES cycles and then returns it to 0. fail_o is high from the first recovery cycle until the next accepted start.
- R8: start_i has no effect while the sequencer is busy, that is, from the accepted start up to done or the end of recovery. A start given in the idle, done or failed state is accepted, and in the next cycle done_o, fail_o and gen_o read 0.
- R9: done_o and fail_o are never high together, and done_o stays high with ltssm_en_o still set until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin bring-up (single-cycle pulse) |
| link_tmo_i | input | TW | Cycle budget for each link-up wait |
| status_i | input | 32 | PHY debug status: bit 4 link up, bit 29 training |
| spd_ctl_i | input | 32 | Width/speed control readback: bit 17 speed change pending |
| lcs_i | input | 32 | Link control/status: bits 19:16 current generation |
| max_speed_o | output | 4 | Max link speed field: 1 = Gen1, 2 = Gen2 |
| ltssm_en_o | output | 1 | Link training enable |
| speed_req_o | output | 1 | Pulse that sets the directed speed-change bit |
| rx_ovrd_o | output | 16 | PHY receiver override word |
| done_o | output | 1 | Link up at negotiated speed |
| fail_o | output | 1 | Bring-up failed |
| gen_o | output | 4 | Negotiated generation |

## Verification
The bench aims at both edges of the poll limit. A busy bit that clears on the 200th read must still give success, and one that stays set for 200 reads must start recovery exactly 201 cycles after the pulse. An off-by-one poll counter shifts that point or turns a success into a failure. The link timeout is measured to the exact cycle, and the settle wait is tried with training held one cycle less and one cycle more than its budget, which exposes a comparison made against the wrong bound. Start pulses given in the middle of the poll and during recovery show whether a busy sequencer restarts: a faulty design would drop the speed cap back to Gen1 or cut the override window short. Random junk in the unused status bits catches a design that reads the wrong bit positions or the wrong generation field.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  localparam logic [3:0] SPD_GEN1 = 4'd1;
  localparam logic [3:0] SPD_GEN2 = 4'd2;
  localparam int LINK_UP_BIT  = 4;
  localparam int TRAIN_BIT    = 29;
  localparam int SPD_CHG_BIT  = 17;
  localparam int GEN_LSB      = 16;
  localparam int RX_DATA_BIT  = 5;
  localparam int RX_PLL_BIT   = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CAP, ST_WAIT1, ST_RAISE, ST_REQ,
    ST_POLL, ST_WAIT2, ST_RECOV, ST_DONE, ST_FAILED
  } lbs_state_e;
endpackage

// File: rtl/lbs_cnt.sv
module lbs_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/lbs_fsm.sv
module lbs_fsm
  import lbs_pkg::*;
#(
  parameter int TW           = 16,
  parameter int CW           = 19,
  parameter int POLL_MAX     = 200,
  parameter int RECOV_CYCLES = 500000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] link_tmo_i,
  input  logic [31:0]   status_i,
  input  logic [31:0]   spd_ctl_i,
  input  logic [31:0]   lcs_i,
  input  logic [CW-1:0] cnt_i,
  output logic          cnt_clr_o,
  output logic [3:0]    max_speed_o,
  output logic          ltssm_en_o,
  output logic          speed_req_o,
  output logic [15:0]   rx_ovrd_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [3:0]    gen_o
);
  localparam logic [CW-1:0] POLL_LAST  = CW'(POLL_MAX - 1);
  localparam logic [CW-1:0] RECOV_LAST = CW'(RECOV_CYCLES - 1);
  localparam logic [15:0]   OVRD_WORD  = 16'((1 << RX_DATA_BIT) | (1 << RX_PLL_BIT));

  lbs_state_e st_q, st_d;
  logic [CW-1:0] tmo;
  logic link_up, training, chg_pending, busy;

  assign tmo         = CW'(link_tmo_i);
  assign link_up     = status_i[LINK_UP_BIT];
  assign training    = status_i[TRAIN_BIT];
  assign chg_pending = spd_ctl_i[SPD_CHG_BIT];
  assign busy        = !(st_q inside {ST_IDLE, ST_DONE, ST_FAILED});

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE, ST_FAILED: if (start_i) st_d = ST_CAP;
      ST_CAP:   st_d = ST_WAIT1;
      ST_WAIT1: begin
        if (link_up)           st_d = ST_RAISE;
        else if (cnt_i == tmo) st_d = ST_RECOV;
      end
      ST_RAISE: st_d = ST_REQ;
      ST_REQ:   st_d = ST_POLL;
      ST_POLL: begin
        if (!chg_pending)            st_d = ST_WAIT2;
        else if (cnt_i == POLL_LAST) st_d = ST_RECOV;
      end
      ST_WAIT2: begin
        if (link_up && !training) st_d = ST_DONE;
        else if (cnt_i == tmo)    st_d = ST_RECOV;
      end
      ST_RECOV: if (cnt_i == RECOV_LAST) st_d = ST_FAILED;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign cnt_clr_o = (st_d != st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      max_speed_o <= '0;
      ltssm_en_o  <= 1'b0;
      gen_o       <= '0;
    end else begin
      st_q <= st_d;
      if (st_d == ST_CAP && st_q != ST_CAP) begin
        max_speed_o <= SPD_GEN1;
        ltssm_en_o  <= 1'b0;
        gen_o       <= '0;
      end
      if (st_q == ST_CAP) ltssm_en_o <= 1'b1;
      if (st_d == ST_RAISE && st_q == ST_WAIT1) max_speed_o <= SPD_GEN2;
      if (st_d == ST_DONE && st_q == ST_WAIT2) gen_o <= lcs_i[GEN_LSB +: 4];
    end
  end

  assign speed_req_o = (st_q == ST_REQ);
  assign rx_ovrd_o   = (st_q == ST_RECOV) ? OVRD_WORD : 16'h0000;
  assign done_o      = (st_q == ST_DONE);
  assign fail_o      = (st_q == ST_RECOV) || (st_q == ST_FAILED);

  assert_gen1_at_train_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ltssm_en_o) |-> max_speed_o == SPD_GEN1);
  assert_gen2_at_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    speed_req_o |-> max_speed_o == SPD_GEN2);
  assert_req_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    speed_req_o |=> !speed_req_o);
  assert_poll_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_POLL |-> cnt_i < CW'(POLL_MAX));
  assert_done_gen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> gen_o == $past(lcs_i[GEN_LSB +: 4]));
  assert_ovrd_in_fail_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovrd_o != 16'h0 |-> fail_o);
  assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && start_i && ltssm_en_o |=> ltssm_en_o);
  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq #(
  parameter int TW           = 16,
  parameter int POLL_MAX     = 200,
  parameter int RECOV_CYCLES = 500000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] link_tmo_i,
  input  logic [31:0]   status_i,
  input  logic [31:0]   spd_ctl_i,
  input  logic [31:0]   lcs_i,
  output logic [3:0]    max_speed_o,
  output logic          ltssm_en_o,
  output logic          speed_req_o,
  output logic [15:0]   rx_ovrd_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [3:0]    gen_o
);
  localparam int RW  = $clog2(RECOV_CYCLES + 1);
  localparam int PW  = $clog2(POLL_MAX + 1);
  localparam int CW0 = (TW > RW) ? TW : RW;
  localparam int CW  = (CW0 > PW) ? CW0 : PW;

  logic [CW-1:0] cnt;
  logic          cnt_clr;

  lbs_cnt #(.W(CW)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .cnt_o  (cnt)
  );

  lbs_fsm #(
    .TW(TW), .CW(CW), .POLL_MAX(POLL_MAX), .RECOV_CYCLES(RECOV_CYCLES)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .link_tmo_i  (link_tmo_i),
    .status_i    (status_i),
    .spd_ctl_i   (spd_ctl_i),
    .lcs_i       (lcs_i),
    .cnt_i       (cnt),
    .cnt_clr_o   (cnt_clr),
    .max_speed_o (max_speed_o),
    .ltssm_en_o  (ltssm_en_o),
    .speed_req_o (speed_req_o),
    .rx_ovrd_o   (rx_ovrd_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .gen_o       (gen_o)
  );
endmodule

// File: tb/test_link_bringup_seq.sv
`timescale 1ns/1ps
module test_link_bringup_seq;
  localparam int RECOV = 40;
  localparam int TMO   = 30;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [15:0] link_tmo_i = 16'(TMO);
  logic [31:0] status_i, spd_ctl_i, lcs_i;
  logic [3:0]  max_speed_o, gen_o;
  logic        ltssm_en_o, speed_req_o, done_o, fail_o;
  logic [15:0] rx_ovrd_o;

  always #2 clk_i = ~clk_i;

  link_bringup_seq #(.TW(16), .POLL_MAX(200), .RECOV_CYCLES(RECOV)) i_link_bringup_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .link_tmo_i(link_tmo_i),
    .status_i(status_i), .spd_ctl_i(spd_ctl_i), .lcs_i(lcs_i),
    .max_speed_o(max_speed_o), .ltssm_en_o(ltssm_en_o), .speed_req_o(speed_req_o),
    .rx_ovrd_o(rx_ovrd_o), .done_o(done_o), .fail_o(fail_o), .gen_o(gen_o));

  // core model
  int m_up_delay = 0, m_busy_len = 0, m_train_len = 0;
  int en_cnt = 0, busy_cnt = 0, train_cnt = 0;
  logic [31:0] st_junk = 32'h0, sc_junk = 32'h0, lcs_w = 32'h0;
  logic up_w, trn_w, chg_w;

  always @(posedge clk_i) begin
    if (!ltssm_en_o) begin
      en_cnt <= 0; busy_cnt <= 0; train_cnt <= 0;
    end else begin
      if (en_cnt < 1000000) en_cnt <= en_cnt + 1;
      if (speed_req_o) begin
        busy_cnt <= m_busy_len; train_cnt <= m_train_len;
      end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      else if (train_cnt != 0) train_cnt <= train_cnt - 1;
    end
  end

  assign up_w  = ltssm_en_o && (en_cnt >= m_up_delay);
  assign trn_w = (train_cnt != 0);
  assign chg_w = (busy_cnt != 0);
  assign status_i  = (st_junk & ~32'h2000_0010) | (32'(up_w) << 4) | (32'(trn_w) << 29);
  assign spd_ctl_i = (sc_junk & ~32'h0002_0000) | (32'(chg_w) << 17);
  assign lcs_i     = lcs_w;

  // monitor
  int ncyc = 0, t_lt = 0, t_req = 0, t_ov = 0, n_req = 0, ovrd_len = 0, ovrd_bad = 0, bad_g1 = 0;
  logic p_lt = 1'b0, p_ov = 1'b0;
  always @(negedge clk_i) begin
    ncyc++;
    if (ltssm_en_o && !p_lt) begin
      t_lt = ncyc;
      if (max_speed_o != 4'd1) bad_g1++;
    end
    if (speed_req_o) begin
      t_req = ncyc; n_req++;
    end
    if (rx_ovrd_o != 16'h0) begin
      if (!p_ov) t_ov = ncyc;
      ovrd_len++;
      if (rx_ovrd_o != 16'h0028) ovrd_bad++;
    end
    p_lt = ltssm_en_o;
    p_ov = (rx_ovrd_o != 16'h0);
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_fail(int d, int b, int t);
    return (d > TMO) || (b >= 200) || (t > TMO + 1);
  endfunction

  task automatic setup(int d, int b, int t, logic [3:0] g);
    m_up_delay = d; m_busy_len = b; m_train_len = t;
    lcs_w = ($urandom & ~32'h000F_0000) | (32'(g) << 16);
  endtask

  task automatic kick();
    @(negedge clk_i);
    start_i = 1'b1;
    n_req = 0; ovrd_len = 0; ovrd_bad = 0; bad_g1 = 0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!done_o && !fail_o && gen_o == 4'd0, "R8 accepted start clears flags",
        {done_o, fail_o, gen_o}, 0);
  endtask

  task automatic finish_wait();
    while (!(done_o || (fail_o && rx_ovrd_o == 16'h0))) @(negedge clk_i);
  endtask

  task automatic run(int d, int b, int t, logic [3:0] g);
    bit ef;
    setup(d, b, t, g);
    kick();
    finish_wait();
    ef = exp_fail(d, b, t);
    chk(fail_o == ef && done_o == !ef, "R5 outcome", fail_o, ef);
    chk(bad_g1 == 0, "R2 gen1 cap at training enable", bad_g1, 0);
    chk(!(done_o && fail_o), "R9 done/fail exclusive", done_o & fail_o, 0);
    if (d <= TMO) chk(n_req == 1, "R3 single speed request", n_req, 1);
    if (!ef) begin
      chk(gen_o == g, "R5 negotiated gen", gen_o, g);
      chk(ltssm_en_o && max_speed_o == 4'd2, "R9 done holds link enabled", ltssm_en_o, 1);
    end else begin
      chk(ovrd_len == RECOV, "R7 recovery length", ovrd_len, RECOV);
      chk(ovrd_bad == 0, "R7 override word 0x0028", ovrd_bad, 0);
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    st_junk = $urandom; sc_junk = $urandom;
    repeat (3) @(negedge clk_i);
    chk(!done_o && !fail_o && gen_o == 0 && !ltssm_en_o && !speed_req_o &&
        max_speed_o == 0 && rx_ovrd_o == 0, "R1 reset state", max_speed_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(max_speed_o == 0 && !ltssm_en_o, "R1 idle after reset", ltssm_en_o, 0);

    run(5, 10, 4, 4'd2);
    run(0, 0, 0, 4'd1);

    // R4 boundary: busy clears on the 200th read
    run(3, 199, 2, 4'd2);
    // R4 boundary: 200 busy reads -> fail, recovery 201 cycles after pulse
    run(3, 200, 2, 4'd2);
    chk(t_ov - t_req == 201, "R4 poll timeout timing", t_ov - t_req, 201);

    // R6 first wait timeout exact
    run(TMO + 1, 0, 0, 4'd1);
    chk(t_ov - t_lt == TMO + 1, "R6 link wait timeout timing", t_ov - t_lt, TMO + 1);
    run(TMO, 0, 0, 4'd1);
    chk(done_o, "R6 link up on last allowed sample", done_o, 1);

    // R6 second wait: settle boundary
    run(2, 5, TMO + 1, 4'd2);
    chk(done_o, "R6 settle on last allowed sample", done_o, 1);
    run(2, 5, TMO + 2, 4'd2);
    chk(fail_o, "R6 settle timeout", fail_o, 1);

    // R8 start during poll is ignored
    setup(4, 150, 3, 4'd2);
    kick();
    while (!speed_req_o) @(negedge clk_i);
    repeat (5) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    chk(max_speed_o == 4'd2 && ltssm_en_o, "R8 start ignored while polling", max_speed_o, 2);
    finish_wait();
    chk(done_o && gen_o == 4'd2, "R8 sequence completes after ignored start", done_o, 1);

    // R8 start during recovery is ignored
    setup(4, 300, 0, 4'd2);
    kick();
    while (rx_ovrd_o == 16'h0) @(negedge clk_i);
    repeat (10) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    chk(rx_ovrd_o == 16'h0028 && fail_o, "R8 start ignored in recovery", rx_ovrd_o, 16'h0028);
    finish_wait();
    chk(ovrd_len == RECOV, "R7 recovery not cut short", ovrd_len, RECOV);
    chk(fail_o && !done_o, "R7 fail held after recovery", fail_o, 1);

    // random mix
    for (int i = 0; i < 24; i++) begin
      int d, b, t;
      logic [3:0] g;
      d = $urandom_range(0, TMO + 8);
      b = ($urandom_range(0, 5) == 0) ? $urandom_range(195, 260) : $urandom_range(0, 60);
      t = $urandom_range(0, TMO + 6);
      g = 4'($urandom_range(1, 15));
      run(d, b, t, g);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule